// File: doc/BRIEF.md
# Iterative Single-Precision Floating-Point Divider

This block divides one 32-bit binary floating-point operand (the dividend) by another (the divisor). A caller raises `start` for one cycle with both operands present. The block latches them and raises `busy`. It then sorts out the special operand classes first: zeros, infinities and NaNs. Those cases return a fixed answer straight away, without any arithmetic.

For two ordinary operands, the block forms the result exponent as the difference of the stored exponents with the bias of 127 restored. It then divides the two 24-bit significands with a restoring shift-and-subtract loop that yields one quotient bit per clock. It normalizes the quotient, rounds to nearest-even, and checks the final exponent against the representable range.

The answer appears on `result` with three exception flags during a one-cycle `done` pulse. The answer and the flags stay unchanged until the next `done`. Subnormal operands are treated as zero, and results too small for a normal exponent are flushed to a signed zero.

Top module: `fp_divider`

## Requirements
- R1: After reset, `busy`, `done`, `result` and all flags are 0. A `start` seen while `busy` is low is accepted: `busy` is high from the next cycle until it falls in the cycle `done` pulses, and `done` lasts exactly one cycle.
- R2: A `start` raised while `busy` is high is ignored. It produces no extra `done`, and the result of the operation in flight is unchanged.
- R3: An operand whose exponent field (bits 30:23) is 0 counts as zero. A zero dividend over a finite nonzero divisor gives a zero whose sign (bit 31) is the XOR of the operand signs, with no flag set, one clock edge after acceptance.
- R4: A finite nonzero dividend over a zero divisor gives a signed infinity (exponent field all ones, fraction 0) and sets `dz_flag`.
- R5: Zero over zero, infinity over infinity, and any NaN operand (exponent all ones, fraction nonzero) give the quiet NaN 0x7FC00000 with no flag set.
- R6: Infinity over a finite or zero divisor gives a signed infinity with no flag set. A finite dividend over infinity gives a signed zero with no flag set.
- R7: For normal operands, the result exponent is the dividend exponent minus the divisor exponent plus 127, and the sign is the XOR of the operand signs. The 24-bit significand is rounded to nearest-even. The result is due 28 clock edges after acceptance.
- R8: When the significand quotient is below 1.0, it is shifted left by one and the exponent is reduced by one before rounding. If rounding carries out, the exponent is raised by one.
- R9: A final exponent of 255 or more gives a signed infinity and sets `ovf_flag`.
- R10: A final exponent of 0 or less gives a signed zero and sets `unf_flag`.
- R11: At most one of `ovf_flag`, `unf_flag` and `dz_flag` is set with any result. The flags change only together with `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse; accepted only while `busy` is low |
| op_a | input | 32 | Dividend, single-precision |
| op_b | input | 32 | Divisor, single-precision |
| busy | output | 1 | High from the cycle after acceptance until `done` |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | 32 | Quotient, held until the next `done` |
| ovf_flag | output | 1 | Exponent overflow with the current result |
| unf_flag | output | 1 | Exponent underflow with the current result |
| dz_flag | output | 1 | Finite nonzero dividend divided by zero |

## Verification
The latency depends on the operand class:
- Special-operand results arrive one clock edge after the edge that accepts `start`.
- Arithmetic results arrive 28 edges after it: one edge for classification, 26 loop iterations, and one edge for rounding and packing.

The driver task records, for every request, the expected word and flags together with the exact cycle number on which `done` must appear. The monitor pops that item when it sees `done` and compares the value, the flags and the cycle number. A `done` that arrives early, arrives late, or has no matching request is reported as a mismatch.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RUN,
    ST_PACK
  } fdiv_state_e;

  typedef struct packed {
    logic sign;
    logic is_zero;
    logic is_inf;
    logic is_nan;
  } fdiv_class_t;

endpackage

// File: rtl/fdiv_classify.sv
module fdiv_classify
  import fdiv_pkg::*;
#(
  parameter int EXP_W  = SP_EXP_W,
  parameter int FRAC_W = SP_FRAC_W
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output fdiv_class_t           cls,
  output logic [EXP_W-1:0]      expo,
  output logic [FRAC_W:0]       sig
);
  localparam int SIG_W = FRAC_W + 1;

  logic [FRAC_W-1:0] frac;
  logic              exp_max;
  logic              exp_min;

  assign frac    = word[FRAC_W-1:0];
  assign expo    = word[EXP_W+FRAC_W-1:FRAC_W];
  assign exp_max = &expo;
  assign exp_min = ~|expo;

  always_comb begin
    cls.sign    = word[EXP_W+FRAC_W];
    cls.is_zero = exp_min;             // subnormals flushed to zero
    cls.is_inf  = exp_max && (frac == '0);
    cls.is_nan  = exp_max && (frac != '0);
  end

  // hidden one restored; zero significand for zero class
  assign sig = exp_min ? SIG_W'(0) : {1'b1, frac};
endmodule

// File: rtl/fdiv_sig_iter.sv
module fdiv_sig_iter #(
  parameter int SIG_W = 24,
  parameter int ITER  = SIG_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [SIG_W-1:0] dividend,
  input  logic [SIG_W-1:0] divisor,
  output logic [ITER-1:0]  quo,
  output logic             rem_nz
);
  logic [SIG_W:0]   rem_q;
  logic [SIG_W-1:0] dvs_q;
  logic             q_bit;
  logic [SIG_W:0]   rem_nx;

  // one restoring step: compare, subtract when it fits, shift left
  function automatic logic [SIG_W+1:0] restore_step(input logic [SIG_W:0] r,
                                                    input logic [SIG_W-1:0] d);
    logic             ge;
    logic [SIG_W:0]   diff;
    ge   = (r >= {1'b0, d});
    diff = ge ? (r - {1'b0, d}) : r;
    return {ge, diff[SIG_W-1:0], 1'b0};
  endfunction

  assign {q_bit, rem_nx} = restore_step(rem_q, dvs_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      dvs_q <= '0;
      quo   <= '0;
    end else if (load) begin
      rem_q <= {1'b0, dividend};
      dvs_q <= divisor;
      quo   <= '0;
    end else if (step) begin
      rem_q <= rem_nx;
      quo   <= {quo[ITER-2:0], q_bit};
    end
  end

  assign rem_nz = |rem_q;
endmodule

// File: rtl/fdiv_round_pack.sv
module fdiv_round_pack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int ITER   = FRAC_W + 3
) (
  input  logic                     sign,
  input  logic signed [EXP_W+1:0]  exp_pre,
  input  logic [ITER-1:0]          quo,
  input  logic                     rem_nz,
  output logic [EXP_W+FRAC_W:0]    word,
  output logic                     ovf,
  output logic                     unf
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int EW    = EXP_W + 2;
  localparam int EMAX  = (1 << EXP_W) - 1;

  logic                 norm;
  logic [SIG_W-1:0]     mant_raw;
  logic                 rbit;
  logic                 sticky;
  logic                 inc;
  logic [SIG_W:0]       mant_r;
  logic                 carry;
  logic [FRAC_W-1:0]    frac;
  logic signed [EW-1:0] e_adj;

  always_comb begin
    norm     = quo[ITER-1];
    mant_raw = norm ? quo[ITER-1:2] : quo[ITER-2:1];
    rbit     = norm ? quo[1] : quo[0];
    sticky   = norm ? (quo[0] | rem_nz) : rem_nz;
    inc      = rbit & (sticky | mant_raw[0]);
    mant_r   = {1'b0, mant_raw} + {{SIG_W{1'b0}}, inc};
    carry    = mant_r[SIG_W];
    frac     = carry ? mant_r[SIG_W-1:1] : mant_r[SIG_W-2:0];
    e_adj    = exp_pre;
    if (!norm) e_adj = e_adj - EW'(1);
    if (carry) e_adj = e_adj + EW'(1);
    ovf = (e_adj >= EW'(EMAX));
    unf = (e_adj <= EW'(0));
    if (ovf)
      word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (unf)
      word = {sign, {(EXP_W+FRAC_W){1'b0}}};
    else
      word = {sign, e_adj[EXP_W-1:0], frac};
  end
endmodule

// File: rtl/fp_divider.sv
module fp_divider
  import fdiv_pkg::*;
#(
  parameter int EXP_W  = SP_EXP_W,
  parameter int FRAC_W = SP_FRAC_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  output logic                  busy,
  output logic                  done,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  ovf_flag,
  output logic                  unf_flag,
  output logic                  dz_flag
);
  localparam int W     = 1 + EXP_W + FRAC_W;
  localparam int SIG_W = FRAC_W + 1;
  localparam int ITER  = SIG_W + 2;
  localparam int CNT_W = $clog2(ITER);
  localparam int EW    = EXP_W + 2;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

  fdiv_state_e        state;
  logic [W-1:0]       opa_q, opb_q;
  logic [CNT_W-1:0]   cnt;
  fdiv_class_t        cla, clb;
  logic [EXP_W-1:0]   expa, expb;
  logic [SIG_W-1:0]   siga, sigb;
  logic [ITER-1:0]    quo;
  logic               rem_nz;
  logic               res_sign;
  logic signed [EW-1:0] exp_pre;
  logic [W-1:0]       packed_word;
  logic               pk_ovf, pk_unf;

  // named events for the checker
  logic               accept;
  logic               special_hit;
  logic               special_dz;
  logic [W-1:0]       special_word;
  logic               iter_step;
  logic               iter_load;
  logic               last_iter;

  // special-class answer: {hit, dz, word}
  function automatic logic [W+1:0] special_pick(input fdiv_class_t ca,
                                                input fdiv_class_t cb,
                                                input logic sgn);
    logic [W-1:0] qnan, inf, zer;
    qnan = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    inf  = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    zer  = {sgn, {(EXP_W+FRAC_W){1'b0}}};
    if (ca.is_nan || cb.is_nan)                         return {2'b10, qnan};
    else if ((ca.is_zero && cb.is_zero) ||
             (ca.is_inf && cb.is_inf))                  return {2'b10, qnan};
    else if (ca.is_inf)                                 return {2'b10, inf};
    else if (cb.is_zero)                                return {2'b11, inf};
    else if (ca.is_zero || cb.is_inf)                   return {2'b10, zer};
    else                                                return {2'b00, zer};
  endfunction

  // biased exponent difference with the bias put back
  function automatic logic signed [EW-1:0] exp_diff(input logic [EXP_W-1:0] ea,
                                                    input logic [EXP_W-1:0] eb);
    return $signed({2'b00, ea}) - $signed({2'b00, eb}) + EW'(BIAS);
  endfunction

  fdiv_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
    .word(opa_q), .cls(cla), .expo(expa), .sig(siga)
  );
  fdiv_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
    .word(opb_q), .cls(clb), .expo(expb), .sig(sigb)
  );

  assign res_sign = cla.sign ^ clb.sign;
  assign {special_hit, special_dz, special_word} = special_pick(cla, clb, res_sign);
  assign exp_pre  = exp_diff(expa, expb);

  assign accept    = start && !busy;
  assign iter_load = (state == ST_CHECK) && !special_hit;
  assign iter_step = (state == ST_RUN);
  assign last_iter = (cnt == CNT_W'(ITER - 1));

  fdiv_sig_iter #(.SIG_W(SIG_W), .ITER(ITER)) u_iter (
    .clk(clk), .rst_n(rst_n), .load(iter_load), .step(iter_step),
    .dividend(siga), .divisor(sigb), .quo(quo), .rem_nz(rem_nz)
  );

  fdiv_round_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .ITER(ITER)) u_pack (
    .sign(res_sign), .exp_pre(exp_pre), .quo(quo), .rem_nz(rem_nz),
    .word(packed_word), .ovf(pk_ovf), .unf(pk_unf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
      dz_flag  <= 1'b0;
      opa_q    <= '0;
      opb_q    <= '0;
      cnt      <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            opa_q <= op_a;
            opb_q <= op_b;
            busy  <= 1'b1;
            state <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          cnt <= '0;
          if (special_hit) begin
            result   <= special_word;
            dz_flag  <= special_dz;
            ovf_flag <= 1'b0;
            unf_flag <= 1'b0;
            done     <= 1'b1;
            busy     <= 1'b0;
            state    <= ST_IDLE;
          end else begin
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          cnt <= cnt + CNT_W'(1);
          if (last_iter) state <= ST_PACK;
        end
        ST_PACK: begin
          result   <= packed_word;
          ovf_flag <= pk_ovf;
          unf_flag <= pk_unf;
          dz_flag  <= 1'b0;
          done     <= 1'b1;
          busy     <= 1'b0;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker #(
  parameter int W     = 32,
  parameter int EXP_W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         accept,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] result,
  input logic         ovf_flag,
  input logic         unf_flag,
  input logic         dz_flag,
  input logic [W-1:0] opa_q
);
  localparam int FRAC_W = W - 1 - EXP_W;

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r1_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r2_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(opa_q));

  a_r4_dz_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dz_flag) |-> (result[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  a_r9_ovf_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf_flag) |-> (result[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

  a_r10_unf_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && unf_flag) |-> (result[W-2:0] == '0));

  a_r11_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ovf_flag, unf_flag, dz_flag}) <= 1);

  a_r11_flags_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({ovf_flag, unf_flag, dz_flag}));
endmodule

bind fp_divider fdiv_checker #(.W(1 + EXP_W + FRAC_W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy), .done(done),
  .result(result), .ovf_flag(ovf_flag), .unf_flag(unf_flag),
  .dz_flag(dz_flag), .opa_q(opa_q)
);

// File: tb/fp_divider_bench.sv
module fp_divider_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        busy, done, ovf_flag, unf_flag, dz_flag;
  logic [31:0] result;

  localparam int LAT_SPC = 1;
  localparam int LAT_ARI = 28;

  fp_divider u_fp_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(a), .op_b(b),
    .busy(busy), .done(done), .result(result),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag), .dz_flag(dz_flag)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;

  logic [31:0] q_res[$];
  logic [2:0]  q_flg[$];
  int          q_due[$];
  string       q_tag[$];

  // scoreboard driver: flags packed {ovf, unf, dz}
  task automatic issue(input logic [31:0] x, input logic [31:0] y,
                       input logic [31:0] er, input logic [2:0] ef,
                       input int lat, input string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    a = x; b = y; start = 1'b1;
    q_res.push_back(er); q_flg.push_back(ef);
    q_due.push_back(cyc + 1 + lat); q_tag.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    checks++;
    if (busy !== 1'b1) begin
      fails++;
      $display("FAIL R1 busy after accept: got %b expected 1", busy);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      checks++;
      if (q_res.size() == 0) begin
        fails++;
        $display("FAIL R2 unexpected done: result=%h expected no result", result);
      end else begin
        logic [31:0] er;
        logic [2:0]  ef;
        int          due;
        string       tag;
        er = q_res.pop_front(); ef = q_flg.pop_front();
        due = q_due.pop_front(); tag = q_tag.pop_front();
        if (result !== er || {ovf_flag, unf_flag, dz_flag} !== ef || cyc != due) begin
          fails++;
          $display("FAIL %s: result=%h flags=%b cycle=%0d expected %h %b %0d",
                   tag, result, {ovf_flag, unf_flag, dz_flag}, cyc, er, ef, due);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 20000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({busy, done, ovf_flag, unf_flag, dz_flag} !== 5'b0 || result !== 32'h0) begin
      fails++;
      $display("FAIL R1 reset state: busy=%b done=%b result=%h expected all zero",
               busy, done, result);
    end

    // R7 exact quotients, sign handling
    issue(32'h40C00000, 32'h40000000, 32'h40400000, 3'b000, LAT_ARI, "R7 6/2");
    issue(32'h40F00000, 32'hC0200000, 32'hC0400000, 3'b000, LAT_ARI, "R7 7.5/-2.5");
    issue(32'h40400000, 32'h40000000, 32'h3FC00000, 3'b000, LAT_ARI, "R7 3/2");
    // R7 rounding down on the no-shift path
    issue(32'h40E00000, 32'h40400000, 32'h40155555, 3'b000, LAT_ARI, "R7 7/3 round down");
    // R8 quotient below one, rounding up and down
    issue(32'h3F800000, 32'h40400000, 32'h3EAAAAAB, 3'b000, LAT_ARI, "R8 1/3 round up");
    issue(32'h40A00000, 32'h40400000, 32'h3FD55555, 3'b000, LAT_ARI, "R8 5/3 round down");
    issue(32'h3F800000, 32'hC0800000, 32'hBE800000, 3'b000, LAT_ARI, "R8 1/-4");
    issue(32'h3F800000, 32'h40E00000, 32'h3E124925, 3'b000, LAT_ARI, "R8 1/7");

    // R2 start during busy ignored
    issue(32'h40C00000, 32'h40000000, 32'h40400000, 3'b000, LAT_ARI, "R2 held op");
    repeat (3) @(negedge clk);
    a = 32'h3F800000; b = 32'h40400000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    // R9 / R10 range limits
    issue(32'h7F000000, 32'h3F000000, 32'h7F800000, 3'b100, LAT_ARI, "R9 overflow");
    issue(32'hFF000000, 32'h3F000000, 32'hFF800000, 3'b100, LAT_ARI, "R9 negative overflow");
    issue(32'h7F000000, 32'h3F800000, 32'h7F000000, 3'b000, LAT_ARI, "R9 largest exponent kept");
    issue(32'h00800000, 32'h40000000, 32'h00000000, 3'b010, LAT_ARI, "R10 underflow");
    issue(32'h80800000, 32'h40000000, 32'h80000000, 3'b010, LAT_ARI, "R10 negative underflow");

    // R3 zero dividend, subnormal treated as zero
    issue(32'h80000000, 32'h40000000, 32'h80000000, 3'b000, LAT_SPC, "R3 -0/2");
    issue(32'h00000001, 32'h3F800000, 32'h00000000, 3'b000, LAT_SPC, "R3 subnormal/1");
    // R4 divide by zero
    issue(32'h3F800000, 32'h80000000, 32'hFF800000, 3'b001, LAT_SPC, "R4 1/-0");
    // R5 invalid forms
    issue(32'h00000000, 32'h80000000, 32'h7FC00000, 3'b000, LAT_SPC, "R5 0/0");
    issue(32'h7F800000, 32'hFF800000, 32'h7FC00000, 3'b000, LAT_SPC, "R5 inf/inf");
    issue(32'h7FC00001, 32'h3F800000, 32'h7FC00000, 3'b000, LAT_SPC, "R5 NaN operand");
    // R6 infinities
    issue(32'hFF800000, 32'h40000000, 32'hFF800000, 3'b000, LAT_SPC, "R6 -inf/2");
    issue(32'h7F800000, 32'h00000000, 32'h7F800000, 3'b000, LAT_SPC, "R6 inf/0");
    issue(32'h40400000, 32'hFF800000, 32'h80000000, 3'b000, LAT_SPC, "R6 3/-inf");
    // R11 flags cleared by a plain result after a flagged one
    issue(32'h3F800000, 32'h00000000, 32'h7F800000, 3'b001, LAT_SPC, "R11 dz first");
    issue(32'h40C00000, 32'h40000000, 32'h40400000, 3'b000, LAT_ARI, "R11 flags cleared");

    while (q_res.size() != 0 || busy) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule